// File: doc/BRIEF.md
# Checked Message Receiver with Acknowledge

This block terminates a point-to-point message link at one node. Each 52-bit message arrives on a valid/ready handshake. The receiver checks the message's trailer sum against a sum it computes itself. It then looks at the destination field and the 2-bit message type. A request or a reply that is intact and addressed to this node is handed to the local side for one cycle, as its payload, source node and kind. At the same time the receiver queues an acknowledge back to the sender.

Messages that fail the sum are thrown away, and a saturating error counter records them. Messages meant for another node are also thrown away without comment, and so are acknowledges that come in. The local node number is a static input. The acknowledge output has its own valid/ready handshake. While an acknowledge waits, no further message is taken in.

Field layout, from the most significant bit: type [51:50], destination [49:45], source [44:40], address-or-data [39:8], sum [7:0]. Type codes: 00 is a request, 01 is a reply, 10 acknowledges a request, 11 acknowledges a reply.

Top module: `msg_rx_ack`

## Requirements
- R1: The expected sum is formed from bits [51:8], padded with four zero bits at the top to 48 bits and added as six bytes modulo 256. A message is intact only when bits [7:0] equal this sum.
- R2: An intact message of type 00 or 01 whose bits [49:45] equal `node_id` raises `dlv_valid` for exactly one cycle, in the cycle after it is accepted. In that cycle `dlv_src` carries bits [44:40], `dlv_data` carries bits [39:8], and `dlv_is_rsp` is 1 for type 01 and 0 for type 00.
- R3: In the cycle after such a message is accepted, `ack_valid` rises with an acknowledge message. Its type is 10 for a received 00 and 11 for a received 01. Its destination is the received source, its source is `node_id`, its bits [39:8] echo the received ones, and its bits [7:0] are the R1 sum of its own bits [51:8].
- R4: A message that fails R1 causes no delivery and no acknowledge.
- R5: An intact message whose destination differs from `node_id` causes no delivery, no acknowledge and no change to `err_count`.
- R6: An intact acknowledge message (type 10 or 11) addressed to this node causes no delivery, no acknowledge and no change to `err_count`.
- R7: `in_ready` is low while `ack_valid` is high and `ack_ready` is low. A stalled acknowledge keeps its value until it is taken.
- R8: `err_count` rises by one for each accepted message that fails R1 and holds at all ones once it gets there.
- R9: After reset, `ack_valid`, `dlv_valid` and `err_count` are zero.
- R10: When a pending acknowledge is taken, a new message can be accepted in the same cycle, and any acknowledge for it follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 5 | Number of this node (static) |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Receiver can take a message |
| in_msg | input | 52 | Incoming message |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_src | output | 5 | Source node of the delivered message |
| dlv_data | output | 32 | Address-or-data field of the delivered message |
| dlv_is_rsp | output | 1 | 1 = delivered message is a reply, 0 = request |
| ack_valid | output | 1 | Acknowledge message present |
| ack_ready | input | 1 | Link takes the acknowledge |
| ack_msg | output | 52 | Acknowledge message |
| err_count | output | ERR_W (4) | Saturating count of sum failures |

## Verification
Two functions can fall in the same cycle here. The acknowledge output can hand over its pending message while the input takes a new one, and the newly loaded acknowledge must then replace the old one with no gap and no loss. The bench provokes this by sending messages back to back, with `ack_ready` held high and also toggled pseudo-randomly. A behavioural model predicts `in_ready`, the acknowledge and the delivery on every clock. The bench also counts the cycles in which both handshakes complete together.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  localparam int TYPE_W = 2;
  localparam int ID_W   = 5;
  localparam int PAY_W  = 32;
  localparam int CS_W   = 8;
  localparam int HDR_W  = TYPE_W + 2 * ID_W + PAY_W;
  localparam int MSG_W  = HDR_W + CS_W;

  typedef enum logic [TYPE_W-1:0] {
    MT_REQ     = 2'b00,
    MT_RSP     = 2'b01,
    MT_ACK_REQ = 2'b10,
    MT_ACK_RSP = 2'b11
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e         kind;
    logic [ID_W-1:0]   dst;
    logic [ID_W-1:0]   src;
    logic [PAY_W-1:0]  pay;
    logic [CS_W-1:0]   cs;
  } msg_t;
endpackage

// File: rtl/msg_csum.sv
// Byte-wise modulo-2^SUM_W sum of a zero-extended header (R1).
module msg_csum #(
  parameter int DATA_W = 44,
  parameter int SUM_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [SUM_W-1:0]  sum
);
  localparam int NB    = (DATA_W + SUM_W - 1) / SUM_W;
  localparam int EXT_W = NB * SUM_W;

  logic [EXT_W-1:0] ext;
  logic [SUM_W-1:0] part [0:NB];

  assign ext     = EXT_W'(data);
  assign part[0] = '0;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign part[g+1] = part[g] + ext[g*SUM_W +: SUM_W];
  end

  assign sum = part[NB];
endmodule

// File: rtl/msg_err_sat.sv
// Saturating failure counter (R8).
module msg_err_sat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != MAX) cnt <= cnt + 1'b1;
  end

  a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
    cnt == MAX |=> cnt == MAX);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    inc && cnt != MAX |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/msg_ack_gen.sv
// Builds and holds the outgoing acknowledge (R3, R7).
module msg_ack_gen import msg_rx_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              rx_is_rsp,
  input  logic [ID_W-1:0]   rx_src,
  input  logic [ID_W-1:0]   local_id,
  input  logic [PAY_W-1:0]  rx_pay,
  input  logic              ack_ready,
  output logic              ack_valid,
  output logic [MSG_W-1:0]  ack_msg
);
  logic [TYPE_W-1:0] kind;
  logic [HDR_W-1:0]  hdr;
  logic [CS_W-1:0]   cs;

  assign kind = rx_is_rsp ? MT_ACK_RSP : MT_ACK_REQ;
  assign hdr  = {kind, rx_src, local_id, rx_pay};

  msg_csum #(.DATA_W(HDR_W), .SUM_W(CS_W)) u_cs (.data(hdr), .sum(cs));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_msg   <= '0;
    end else if (load) begin
      ack_valid <= 1'b1;
      ack_msg   <= {hdr, cs};
    end else if (ack_ready) begin
      ack_valid <= 1'b0;
    end
  end

  a_r7_ack_hold: assert property (@(posedge clk) disable iff (rst)
    ack_valid && !ack_ready |=> ack_valid && $stable(ack_msg));
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (rst)
    load |-> !ack_valid || ack_ready);
  a_r3_ack_kind: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ack_msg[MSG_W-1]);
  a_r3_ack_src: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ack_msg[CS_W+PAY_W +: ID_W] == local_id);
endmodule

// File: rtl/msg_rx_ack.sv
module msg_rx_ack import msg_rx_pkg::*; #(
  parameter int ERR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MSG_W-1:0]  in_msg,
  output logic              dlv_valid,
  output logic [ID_W-1:0]   dlv_src,
  output logic [PAY_W-1:0]  dlv_data,
  output logic              dlv_is_rsp,
  output logic              ack_valid,
  input  logic              ack_ready,
  output logic [MSG_W-1:0]  ack_msg,
  output logic [ERR_W-1:0]  err_count
);
  msg_t            rx;
  logic [CS_W-1:0] rx_cs;
  logic            take, cs_ok, dst_ok, is_data, hit, bad;

  assign rx = in_msg;

  msg_csum #(.DATA_W(HDR_W), .SUM_W(CS_W)) u_rx_cs (
    .data(in_msg[MSG_W-1:CS_W]), .sum(rx_cs));

  assign in_ready = !ack_valid || ack_ready;
  assign take     = in_valid && in_ready;
  assign cs_ok    = rx_cs == rx.cs;
  assign dst_ok   = rx.dst == node_id;
  assign is_data  = (rx.kind == MT_REQ) || (rx.kind == MT_RSP);
  assign hit      = take && cs_ok && dst_ok && is_data;
  assign bad      = take && !cs_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_src    <= '0;
      dlv_data   <= '0;
      dlv_is_rsp <= 1'b0;
    end else begin
      dlv_valid <= hit;
      if (hit) begin
        dlv_src    <= rx.src;
        dlv_data   <= rx.pay;
        dlv_is_rsp <= rx.kind == MT_RSP;
      end
    end
  end

  msg_ack_gen u_ack (
    .clk(clk), .rst(rst), .load(hit), .rx_is_rsp(rx.kind == MT_RSP),
    .rx_src(rx.src), .local_id(node_id), .rx_pay(rx.pay),
    .ack_ready(ack_ready), .ack_valid(ack_valid), .ack_msg(ack_msg));

  msg_err_sat #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .inc(bad), .cnt(err_count));

  a_r7_ready_stall: assert property (@(posedge clk) disable iff (rst)
    ack_valid && !ack_ready |-> !in_ready);
  a_r2_dlv_with_ack: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ack_valid);
  a_r4_bad_quiet: assert property (@(posedge clk) disable iff (rst)
    bad |=> !dlv_valid);
  a_r5_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
    take && cs_ok && !dst_ok |=> !dlv_valid && $stable(err_count));
  a_r6_ack_in_quiet: assert property (@(posedge clk) disable iff (rst)
    take && cs_ok && !is_data |=> !dlv_valid && $stable(err_count));
endmodule

// File: tb/msg_rx_ack_tb_top.sv
`timescale 1ns/1ps
module msg_rx_ack_tb_top;
  localparam int EW = 4;
  localparam logic [4:0] NODE = 5'd9;

  logic clk = 0, rst = 1;
  logic in_valid = 0, ack_ready = 1;
  logic [51:0] in_msg = '0;
  logic in_ready, dlv_valid, dlv_is_rsp, ack_valid;
  logic [4:0] dlv_src;
  logic [31:0] dlv_data;
  logic [51:0] ack_msg;
  logic [EW-1:0] err_count;

  always #4 clk = ~clk;

  msg_rx_ack #(.ERR_W(EW)) dut_i (
    .clk(clk), .rst(rst), .node_id(NODE), .in_valid(in_valid), .in_ready(in_ready),
    .in_msg(in_msg), .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_data(dlv_data),
    .dlv_is_rsp(dlv_is_rsp), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_msg(ack_msg), .err_count(err_count));

  int n_chk = 0, n_fail = 0, n_dlv = 0, n_ack = 0, n_both = 0, n_stall = 0;
  string phase = "R9";
  int ar_mode = 0;  // 0 always ready, 1 never, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) act=%h exp=%h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [7:0] sum8(input logic [43:0] h);
    logic [47:0] e;
    int s;
    e = {4'b0, h};
    s = 0;
    for (int i = 0; i < 6; i++) s += int'(e[8*i +: 8]);
    return s[7:0];
  endfunction

  function automatic logic [51:0] mk(input logic [1:0] t, input logic [4:0] d,
                                     input logic [4:0] s, input logic [31:0] p,
                                     input bit corrupt);
    logic [43:0] h;
    h = {t, d, s, p};
    return {h, sum8(h) ^ (corrupt ? 8'h01 : 8'h00)};
  endfunction

  // Reference model: state after the most recent edge
  logic m_av = 0, m_dv = 0, m_dk = 0;
  logic [51:0] m_am = '0;
  logic [4:0] m_ds = '0;
  logic [31:0] m_dd = '0;
  int m_err = 0;
  bit seen_rst = 0;

  always @(negedge clk) begin
    logic exp_rdy, acc;
    logic [43:0] ah;
    if (rst) begin
      seen_rst = 1;
      m_av = 0; m_dv = 0; m_err = 0; m_am = '0;
    end else if (seen_rst) begin
      exp_rdy = !m_av || ack_ready;
      chk("R7 in_ready", 64'(in_ready), 64'(exp_rdy));
      chk("R3 ack_valid", 64'(ack_valid), 64'(m_av));
      if (m_av) chk("R3 ack_msg", 64'(ack_msg), 64'(m_am));
      chk("R2 dlv_valid", 64'(dlv_valid), 64'(m_dv));
      if (m_dv) chk("R2 dlv_fields", {dlv_is_rsp, dlv_src, dlv_data},
                    {m_dk, m_ds, m_dd});
      chk("R8 err_count", 64'(err_count), 64'(m_err));
      if (dlv_valid) n_dlv++;
      if (ack_valid && ack_ready) n_ack++;
      if (in_valid && in_ready && ack_valid && ack_ready) n_both++;
      if (in_valid && !in_ready) n_stall++;
      acc = in_valid && exp_rdy;
      m_dv = 0;
      if (m_av && ack_ready) m_av = 0;
      if (acc) begin
        if (sum8(in_msg[51:8]) != in_msg[7:0]) begin
          if (m_err < (1 << EW) - 1) m_err++;
        end else if (in_msg[49:45] == NODE && !in_msg[51]) begin
          ah = {1'b1, in_msg[50], in_msg[44:40], NODE, in_msg[39:8]};
          m_av = 1; m_am = {ah, sum8(ah)};
          m_dv = 1; m_dk = in_msg[50]; m_ds = in_msg[44:40]; m_dd = in_msg[39:8];
        end
      end
    end
  end

  // ack_ready driver
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ack_ready = (ar_mode == 0) ? 1'b1 : (ar_mode == 1) ? 1'b0 : lfsr[3];
  end

  task automatic send(input logic [51:0] m);
    in_valid = 1; in_msg = m;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (phase %s) act=hung exp=done", phase);
    finish_run();
  end

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R9 reset ack_valid", 64'(ack_valid), 0);
    chk("R9 reset dlv_valid", 64'(dlv_valid), 0);
    chk("R9 reset err_count", 64'(err_count), 0);
    @(posedge clk); #1;

    phase = "R2";
    send(mk(2'b00, NODE, 5'd3, 32'h1234_5678, 0)); idle(2);
    phase = "R3";
    send(mk(2'b01, NODE, 5'd30, 32'hDEAD_BEEF, 0)); idle(2);
    phase = "R1";  // all-ones fields: sum wraps several times
    send(mk(2'b01, NODE, 5'd31, 32'hFFFF_FFFF, 0)); idle(2);
    chk("R1 wrap delivered", 64'(n_dlv), 3);

    phase = "R4";
    d0 = n_dlv;
    send(mk(2'b00, NODE, 5'd1, 32'h0000_00A5, 1));
    send(mk(2'b01, NODE, 5'd2, 32'h5555_0000, 1)); idle(2);
    chk("R4 no delivery", 64'(n_dlv), 64'(d0));
    chk("R4 errors counted", 64'(err_count), 2);

    phase = "R5";
    send(mk(2'b00, 5'd8, 5'd1, 32'h0BAD_0001, 0));
    send(mk(2'b01, 5'd10, 5'd1, 32'h0BAD_0002, 0)); idle(2);
    chk("R5 foreign dropped", 64'(n_dlv), 64'(d0));
    chk("R5 err unchanged", 64'(err_count), 2);

    phase = "R6";
    send(mk(2'b10, NODE, 5'd4, 32'h0000_0010, 0));
    send(mk(2'b11, NODE, 5'd4, 32'h0000_0011, 0)); idle(2);
    chk("R6 acks in dropped", 64'(n_dlv), 64'(d0));
    chk("R6 no ack out", 64'(ack_valid), 0);

    phase = "R7";
    ar_mode = 1;
    idle(1);
    send(mk(2'b00, NODE, 5'd6, 32'h7777_0001, 0));
    in_valid = 1; in_msg = mk(2'b01, NODE, 5'd7, 32'h7777_0002, 0);
    idle(5);
    chk("R7 stall seen", 64'(n_stall > 0), 1);
    ar_mode = 0;
    send(mk(2'b01, NODE, 5'd7, 32'h7777_0002, 0)); idle(3);

    phase = "R10";
    for (int i = 0; i < 6; i++)
      send(mk(i[0] ? 2'b01 : 2'b00, NODE, 5'(i), 32'hA000_0000 + 32'(i), 0));
    idle(3);
    chk("R10 overlap seen", 64'(n_both > 0), 1);

    phase = "R10 random";
    ar_mode = 2;
    for (int i = 0; i < 60; i++) begin
      logic [1:0] t;
      t = lfsr[1:0];
      send(mk(t, lfsr[4] ? NODE : 5'(lfsr[9:5]), 5'(lfsr[14:10]),
              {lfsr, lfsr ^ 16'h5A5A}, lfsr[7] & lfsr[2]));
    end
    ar_mode = 0;
    idle(4);

    phase = "R8";
    for (int i = 0; i < 18; i++) send(mk(2'b00, NODE, 5'd1, 32'(i), 1));
    idle(2);
    chk("R8 saturated", 64'(err_count), 64'((1 << EW) - 1));
    send(mk(2'b00, NODE, 5'd1, 32'h1, 1)); idle(2);
    chk("R8 holds at max", 64'(err_count), 64'((1 << EW) - 1));
    finish_run();
  end
endmodule